// File: doc/BRIEF.md
# Single-DWORD Request Issuer

This block is a register file on an AXI4-Lite slave port. A local agent uses it to build one host-bus request at a time and then launch it. The agent writes the target address (two 32-bit halves), an 8-bit format/type code, four byte enables and one 32-bit data word into staging registers. It then writes a separate execute register. That write copies the staged fields into a request holder and presents them on a valid/ready request port. A posted request (a memory write) finishes when the port accepts it. Any other request stays busy until a completion arrives. If the request returns data, the completion word lands in a readable register. Reading the status register reports busy, done and error, and clears done and error.

The upper part of the same register space holds a bank of DMA control registers, which drive an output bus, and a sticky interrupt status register, which is fed by event pulses. All register writes merge bytes under the AXI write strobes. Write address and write data may arrive in either order. The active-low reset asserts asynchronously and is released through a two-stage synchronizer.

Top module: `dword_req_issuer`

## Requirements
- R1: After reset release, the status register, staging registers, read-data register and DMA control registers read 0, and `req_valid_o` is 0.
- R2: The staging registers (0x00 address low, 0x04 address high, 0x08 control, 0x0C write data) read back what was written, merged byte by byte under WSTRB. The control register keeps only bits 11:0: format/type in bits 7:0 and byte enables in bits 11:8.
- R3: A write to the execute register (0x10) while idle raises `req_valid_o` on the cycle the write response is issued. The request carries {high, low} address, the format/type, the byte enables and the data word, and these stay stable until `req_ready_i` is sampled high.
- R4: A request is posted when format/type bit 6 is 1 and bits 4:0 are 0. Such a request clears busy and sets done on the cycle it is accepted.
- R5: Any other request keeps status busy until `cpl_valid_i`, then clears busy and sets done. When format/type bit 6 is 0, `cpl_data_i` is stored in the read-data register (0x18). Otherwise that register is unchanged.
- R6: A write to execute while busy launches nothing, leaves the outstanding request fields unchanged, and sets the error bit.
- R7: Status (0x14) reads as bit 0 busy, bit 1 done, bit 2 error. A read returns the current values and then clears done and error. Busy is not affected by the read.
- R8: A write completes the same way whether AW comes before W, W comes before AW, or both arrive together. Each write gives exactly one B response.
- R9: Mapped offsets return OKAY (00). Unmapped offsets return SLVERR (10) on reads and writes, and an unmapped write changes no register.
- R10: The DMA control registers sit at 0x100 + 4k for k < NUM_DMA. They are read/write with strobe merging and drive `dma_ctrl_o` slice k.
- R11: The interrupt status register at 0x100 + 4*NUM_DMA latches every bit pulsed on `dma_irq_i` until a write of 1 to that bit clears it. When a set and a clear hit the same bit in the same cycle, the set wins.
- R12: A completion that arrives while no non-posted request is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_awaddr_i | input | ADDR_W | Write address |
| s_awvalid_i | input | 1 | Write address valid |
| s_awready_o | output | 1 | Write address ready |
| s_wdata_i | input | 32 | Write data |
| s_wstrb_i | input | 4 | Write byte strobes |
| s_wvalid_i | input | 1 | Write data valid |
| s_wready_o | output | 1 | Write data ready |
| s_bresp_o | output | 2 | Write response |
| s_bvalid_o | output | 1 | Write response valid |
| s_bready_i | input | 1 | Write response ready |
| s_araddr_i | input | ADDR_W | Read address |
| s_arvalid_i | input | 1 | Read address valid |
| s_arready_o | output | 1 | Read address ready |
| s_rdata_o | output | 32 | Read data |
| s_rresp_o | output | 2 | Read response |
| s_rvalid_o | output | 1 | Read data valid |
| s_rready_i | input | 1 | Read data ready |
| req_valid_o | output | 1 | Request valid |
| req_ready_i | input | 1 | Request accepted |
| req_addr_o | output | 64 | Request target address |
| req_fmt_o | output | 8 | Request format/type code |
| req_be_o | output | 4 | Request byte enables |
| req_data_o | output | 32 | Request data word |
| cpl_valid_i | input | 1 | Completion strobe |
| cpl_data_i | input | 32 | Completion data word |
| dma_ctrl_o | output | NUM_DMA*32 | DMA control register contents |
| dma_irq_i | input | IRQ_W | Interrupt event pulses |

## Verification
The assertions assume that the AXI master keeps each valid and its payload asserted until the matching ready is seen. They also assume it holds BREADY and RREADY so that responses are drained. `cpl_valid_i` and `dma_irq_i` may pulse at any time. The bench drives every input half a cycle away from the rising edge. It holds each AXI valid until the handshake, keeps the ready inputs for the response channels high, and pulses completions only for single cycles. Idle-time completions are sent on purpose to exercise R12.

// File: rtl/dri_pkg.sv
package dri_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned HADDR_W = 64;
  localparam logic [31:0]  DMA_BASE = 32'h0000_0100;
  localparam logic [1:0]   RESP_OKAY   = 2'b00;
  localparam logic [1:0]   RESP_SLVERR = 2'b10;

  typedef enum logic [3:0] {
    RG_ADDR_LO, RG_ADDR_HI, RG_CTRL, RG_WDATA, RG_EXEC,
    RG_STATUS, RG_RDATA, RG_DMA_CTRL, RG_DMA_IRQ, RG_NONE
  } reg_sel_e;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} req_state_e;

  typedef struct packed {
    logic [HADDR_W-1:0] addr;
    logic [7:0]         fmt;
    logic [3:0]         be;
    logic [WORD_W-1:0]  data;
  } req_t;

  function automatic reg_sel_e decode_sel(input logic [31:0] a, input int unsigned n_dma);
    reg_sel_e   s;
    logic [31:0] k;
    s = RG_NONE;
    k = (a - DMA_BASE) >> 2;
    if (a < DMA_BASE) begin
      case (a[7:2])
        6'd0:    s = RG_ADDR_LO;
        6'd1:    s = RG_ADDR_HI;
        6'd2:    s = RG_CTRL;
        6'd3:    s = RG_WDATA;
        6'd4:    s = RG_EXEC;
        6'd5:    s = RG_STATUS;
        6'd6:    s = RG_RDATA;
        default: s = RG_NONE;
      endcase
    end else if (k < 32'(n_dma)) begin
      s = RG_DMA_CTRL;
    end else if (k == 32'(n_dma)) begin
      s = RG_DMA_IRQ;
    end
    return s;
  endfunction

  function automatic logic [7:0] decode_idx(input logic [31:0] a);
    logic [31:0] k;
    k = (a - DMA_BASE) >> 2;
    return k[7:0];
  endfunction

  function automatic logic [WORD_W-1:0] strb_mask(input logic [3:0] strb);
    return {{8{strb[3]}}, {8{strb[2]}}, {8{strb[1]}}, {8{strb[0]}}};
  endfunction

  function automatic logic [WORD_W-1:0] byte_merge(input logic [WORD_W-1:0] old_v,
                                                   input logic [WORD_W-1:0] new_v,
                                                   input logic [3:0]        strb);
    return (old_v & ~strb_mask(strb)) | (new_v & strb_mask(strb));
  endfunction

  function automatic logic is_posted(input logic [7:0] f);
    return f[6] && (f[4:0] == 5'd0);
  endfunction

  function automatic logic wants_data(input logic [7:0] f);
    return !f[6];
  endfunction
endpackage

// File: rtl/dri_axil_front.sv
module dri_axil_front #(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] awaddr_i,
  input  logic              awvalid_i,
  output logic              awready_o,
  input  logic [31:0]       wdata_i,
  input  logic [3:0]        wstrb_i,
  input  logic              wvalid_i,
  output logic              wready_o,
  output logic [1:0]        bresp_o,
  output logic              bvalid_o,
  input  logic              bready_i,
  input  logic [ADDR_W-1:0] araddr_i,
  input  logic              arvalid_i,
  output logic              arready_o,
  output logic [31:0]       rdata_o,
  output logic [1:0]        rresp_o,
  output logic              rvalid_o,
  input  logic              rready_i,
  output logic              wr_go_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [31:0]       wr_data_o,
  output logic [3:0]        wr_strb_o,
  input  logic              wr_ok_i,
  output logic              rd_go_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [31:0]       rd_data_i,
  input  logic              rd_ok_i
);
  import dri_pkg::*;

  logic              aw_have_q, aw_have_d;
  logic              w_have_q, w_have_d;
  logic [ADDR_W-1:0] aw_addr_q;
  logic [31:0]       w_data_q;
  logic [3:0]        w_strb_q;
  logic              bvalid_q, bvalid_d;
  logic [1:0]        bresp_q, bresp_d;
  logic              rvalid_q, rvalid_d;
  logic [31:0]       rdata_q, rdata_d;
  logic [1:0]        rresp_q, rresp_d;
  logic              aw_take, w_take;

  assign awready_o = ~aw_have_q;
  assign wready_o  = ~w_have_q;
  assign arready_o = ~rvalid_q;
  assign aw_take   = awvalid_i & awready_o;
  assign w_take    = wvalid_i & wready_o;
  assign wr_go_o   = aw_have_q & w_have_q & ~bvalid_q;
  assign wr_addr_o = aw_addr_q;
  assign wr_data_o = w_data_q;
  assign wr_strb_o = w_strb_q;
  assign rd_go_o   = arvalid_i & arready_o;
  assign rd_addr_o = araddr_i;
  assign bvalid_o  = bvalid_q;
  assign bresp_o   = bresp_q;
  assign rvalid_o  = rvalid_q;
  assign rdata_o   = rdata_q;
  assign rresp_o   = rresp_q;

  always_comb begin
    aw_have_d = aw_have_q;
    w_have_d  = w_have_q;
    bvalid_d  = bvalid_q;
    bresp_d   = bresp_q;
    rvalid_d  = rvalid_q;
    rdata_d   = rdata_q;
    rresp_d   = rresp_q;
    if (aw_take) aw_have_d = 1'b1;
    if (w_take)  w_have_d  = 1'b1;
    if (wr_go_o) begin
      aw_have_d = 1'b0;
      w_have_d  = 1'b0;
      bvalid_d  = 1'b1;
      bresp_d   = wr_ok_i ? RESP_OKAY : RESP_SLVERR;
    end else if (bready_i) begin
      bvalid_d  = 1'b0;
    end
    if (rd_go_o) begin
      rvalid_d = 1'b1;
      rdata_d  = rd_ok_i ? rd_data_i : 32'd0;
      rresp_d  = rd_ok_i ? RESP_OKAY : RESP_SLVERR;
    end else if (rready_i) begin
      rvalid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aw_have_q <= 1'b0;
      w_have_q  <= 1'b0;
      bvalid_q  <= 1'b0;
      bresp_q   <= RESP_OKAY;
      rvalid_q  <= 1'b0;
      rdata_q   <= 32'd0;
      rresp_q   <= RESP_OKAY;
    end else begin
      aw_have_q <= aw_have_d;
      w_have_q  <= w_have_d;
      bvalid_q  <= bvalid_d;
      bresp_q   <= bresp_d;
      rvalid_q  <= rvalid_d;
      rdata_q   <= rdata_d;
      rresp_q   <= rresp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (aw_take) aw_addr_q <= awaddr_i;
    if (w_take) begin
      w_data_q <= wdata_i;
      w_strb_q <= wstrb_i;
    end
  end
endmodule

// File: rtl/dri_req_ctrl.sv
module dri_req_ctrl (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  dri_pkg::reg_sel_e wr_sel_i,
  input  logic [31:0]       wr_data_i,
  input  logic [3:0]        wr_strb_i,
  input  logic              stat_rd_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output dri_pkg::req_t     req_o,
  input  logic              cpl_valid_i,
  input  logic [31:0]       cpl_data_i,
  output logic [31:0]       addr_lo_o,
  output logic [31:0]       addr_hi_o,
  output logic [11:0]       ctrl_o,
  output logic [31:0]       wdata_o,
  output logic [31:0]       rdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  import dri_pkg::*;

  req_state_e  state_q, state_d;
  logic [31:0] addr_lo_q, addr_lo_d, addr_hi_q, addr_hi_d, wdata_q, wdata_d;
  logic [11:0] ctrl_q, ctrl_d;
  logic [31:0] rdata_q, rdata_d;
  req_t        req_q, req_d;
  logic        done_q, done_d, err_q, err_d;
  logic        lo_en, hi_en, ctrl_en, wd_en, rd_en, req_en;
  logic        exec, launch, accept, cpl_hit, finish;

  assign exec    = wr_en_i && (wr_sel_i == RG_EXEC);
  assign launch  = exec && (state_q == ST_IDLE);
  assign accept  = (state_q == ST_ISSUE) && req_ready_i;
  assign cpl_hit = (state_q == ST_WAIT) && cpl_valid_i;
  assign finish  = (accept && is_posted(req_q.fmt)) || cpl_hit;

  assign lo_en   = wr_en_i && (wr_sel_i == RG_ADDR_LO);
  assign hi_en   = wr_en_i && (wr_sel_i == RG_ADDR_HI);
  assign ctrl_en = wr_en_i && (wr_sel_i == RG_CTRL);
  assign wd_en   = wr_en_i && (wr_sel_i == RG_WDATA);
  assign rd_en   = cpl_hit && wants_data(req_q.fmt);
  assign req_en  = launch;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (launch) state_d = ST_ISSUE;
      ST_ISSUE: if (req_ready_i) state_d = is_posted(req_q.fmt) ? ST_IDLE : ST_WAIT;
      ST_WAIT:  if (cpl_valid_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
    addr_lo_d = byte_merge(addr_lo_q, wr_data_i, wr_strb_i);
    addr_hi_d = byte_merge(addr_hi_q, wr_data_i, wr_strb_i);
    ctrl_d    = 12'(byte_merge({20'd0, ctrl_q}, wr_data_i, wr_strb_i));
    wdata_d   = byte_merge(wdata_q, wr_data_i, wr_strb_i);
    rdata_d   = cpl_data_i;
    req_d     = '{addr: {addr_hi_q, addr_lo_q}, fmt: ctrl_q[7:0],
                  be: ctrl_q[11:8], data: wdata_q};
    done_d    = finish ? 1'b1 : (stat_rd_i ? 1'b0 : done_q);
    err_d     = (exec && !launch) ? 1'b1 : (stat_rd_i ? 1'b0 : err_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      addr_lo_q <= 32'd0;
      addr_hi_q <= 32'd0;
      ctrl_q    <= 12'd0;
      wdata_q   <= 32'd0;
      rdata_q   <= 32'd0;
      req_q     <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
      if (lo_en)   addr_lo_q <= addr_lo_d;
      if (hi_en)   addr_hi_q <= addr_hi_d;
      if (ctrl_en) ctrl_q    <= ctrl_d;
      if (wd_en)   wdata_q   <= wdata_d;
      if (rd_en)   rdata_q   <= rdata_d;
      if (req_en)  req_q     <= req_d;
    end
  end

  assign req_valid_o = (state_q == ST_ISSUE);
  assign req_o       = req_q;
  assign addr_lo_o   = addr_lo_q;
  assign addr_hi_o   = addr_hi_q;
  assign ctrl_o      = ctrl_q;
  assign wdata_o     = wdata_q;
  assign rdata_o     = rdata_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;
endmodule

// File: rtl/dri_dma_bank.sv
module dri_dma_bank #(
  parameter int unsigned NUM_DMA = 4,
  parameter int unsigned IRQ_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  dri_pkg::reg_sel_e wr_sel_i,
  input  logic [7:0]        wr_idx_i,
  input  logic [31:0]       wr_data_i,
  input  logic [3:0]        wr_strb_i,
  input  logic [IRQ_W-1:0]  irq_i,
  output logic [31:0]       ctrl_o [NUM_DMA],
  output logic [IRQ_W-1:0]  irq_o
);
  import dri_pkg::*;

  logic [IRQ_W-1:0] irq_q, irq_d, clr_mask;
  logic             irq_wr;

  for (genvar g = 0; g < NUM_DMA; g++) begin : g_ctrl
    logic [31:0] val_q, val_d;
    logic        en;
    assign en    = wr_en_i && (wr_sel_i == RG_DMA_CTRL) && (wr_idx_i == 8'(g));
    assign val_d = byte_merge(val_q, wr_data_i, wr_strb_i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  val_q <= 32'd0;
      else if (en) val_q <= val_d;
    end
    assign ctrl_o[g] = val_q;
  end

  assign irq_wr   = wr_en_i && (wr_sel_i == RG_DMA_IRQ);
  assign clr_mask = irq_wr ? IRQ_W'(wr_data_i & strb_mask(wr_strb_i)) : '0;

  always_comb begin
    irq_d = (irq_q & ~clr_mask) | irq_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/dword_req_issuer.sv
module dword_req_issuer #(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned NUM_DMA = 4,
  parameter int unsigned IRQ_W   = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     s_awaddr_i,
  input  logic                  s_awvalid_i,
  output logic                  s_awready_o,
  input  logic [31:0]           s_wdata_i,
  input  logic [3:0]            s_wstrb_i,
  input  logic                  s_wvalid_i,
  output logic                  s_wready_o,
  output logic [1:0]            s_bresp_o,
  output logic                  s_bvalid_o,
  input  logic                  s_bready_i,
  input  logic [ADDR_W-1:0]     s_araddr_i,
  input  logic                  s_arvalid_i,
  output logic                  s_arready_o,
  output logic [31:0]           s_rdata_o,
  output logic [1:0]            s_rresp_o,
  output logic                  s_rvalid_o,
  input  logic                  s_rready_i,
  output logic                  req_valid_o,
  input  logic                  req_ready_i,
  output logic [63:0]           req_addr_o,
  output logic [7:0]            req_fmt_o,
  output logic [3:0]            req_be_o,
  output logic [31:0]           req_data_o,
  input  logic                  cpl_valid_i,
  input  logic [31:0]           cpl_data_i,
  output logic [NUM_DMA*32-1:0] dma_ctrl_o,
  input  logic [IRQ_W-1:0]      dma_irq_i
);
  import dri_pkg::*;

  logic              rst_meta_q, rst_n_s;
  logic              wr_go, wr_ok, rd_go, rd_ok, wr_en, stat_rd;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [31:0]       wr_data, rd_data;
  logic [3:0]        wr_strb;
  reg_sel_e          wr_sel, rd_sel;
  logic [7:0]        wr_idx, rd_idx;
  req_t              req;
  logic [31:0]       addr_lo, addr_hi, wdata, rdata, dma_rd;
  logic [11:0]       ctrl;
  logic              busy, done, err;
  logic [31:0]       dma_ctrl [NUM_DMA];
  logic [IRQ_W-1:0]  irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_s    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_s    <= rst_meta_q;
    end
  end

  dri_axil_front #(.ADDR_W(ADDR_W)) u_front (
    .clk(clk), .rst_n(rst_n_s),
    .awaddr_i(s_awaddr_i), .awvalid_i(s_awvalid_i), .awready_o(s_awready_o),
    .wdata_i(s_wdata_i), .wstrb_i(s_wstrb_i), .wvalid_i(s_wvalid_i), .wready_o(s_wready_o),
    .bresp_o(s_bresp_o), .bvalid_o(s_bvalid_o), .bready_i(s_bready_i),
    .araddr_i(s_araddr_i), .arvalid_i(s_arvalid_i), .arready_o(s_arready_o),
    .rdata_o(s_rdata_o), .rresp_o(s_rresp_o), .rvalid_o(s_rvalid_o), .rready_i(s_rready_i),
    .wr_go_o(wr_go), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_strb_o(wr_strb),
    .wr_ok_i(wr_ok), .rd_go_o(rd_go), .rd_addr_o(rd_addr), .rd_data_i(rd_data), .rd_ok_i(rd_ok)
  );

  always_comb begin
    wr_sel  = decode_sel(32'(wr_addr), NUM_DMA);
    rd_sel  = decode_sel(32'(rd_addr), NUM_DMA);
    wr_idx  = decode_idx(32'(wr_addr));
    rd_idx  = decode_idx(32'(rd_addr));
    wr_ok   = (wr_sel != RG_NONE);
    rd_ok   = (rd_sel != RG_NONE);
    wr_en   = wr_go && wr_ok;
    stat_rd = rd_go && (rd_sel == RG_STATUS);
  end

  dri_req_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n_s),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data), .wr_strb_i(wr_strb),
    .stat_rd_i(stat_rd),
    .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_o(req),
    .cpl_valid_i(cpl_valid_i), .cpl_data_i(cpl_data_i),
    .addr_lo_o(addr_lo), .addr_hi_o(addr_hi), .ctrl_o(ctrl), .wdata_o(wdata),
    .rdata_o(rdata), .busy_o(busy), .done_o(done), .err_o(err)
  );

  dri_dma_bank #(.NUM_DMA(NUM_DMA), .IRQ_W(IRQ_W)) u_dma (
    .clk(clk), .rst_n(rst_n_s),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .wr_strb_i(wr_strb),
    .irq_i(dma_irq_i), .ctrl_o(dma_ctrl), .irq_o(irq_q)
  );

  for (genvar g = 0; g < NUM_DMA; g++) begin : g_flat
    assign dma_ctrl_o[g*32 +: 32] = dma_ctrl[g];
  end

  always_comb begin
    dma_rd = 32'd0;
    for (int i = 0; i < NUM_DMA; i++) begin
      if (rd_idx == 8'(i)) dma_rd = dma_ctrl[i];
    end
    case (rd_sel)
      RG_ADDR_LO:  rd_data = addr_lo;
      RG_ADDR_HI:  rd_data = addr_hi;
      RG_CTRL:     rd_data = {20'd0, ctrl};
      RG_WDATA:    rd_data = wdata;
      RG_STATUS:   rd_data = {29'd0, err, done, busy};
      RG_RDATA:    rd_data = rdata;
      RG_DMA_CTRL: rd_data = dma_rd;
      RG_DMA_IRQ:  rd_data = 32'(irq_q);
      default:     rd_data = 32'd0;
    endcase
  end

  assign req_addr_o = req.addr;
  assign req_fmt_o  = req.fmt;
  assign req_be_o   = req.be;
  assign req_data_o = req.data;
endmodule

// File: rtl/dri_checker.sv
module dri_checker #(
  parameter int unsigned IRQ_W = 8
) (
  input logic             clk,
  input logic             rst_n_s,
  input logic             req_valid,
  input logic             req_ready,
  input logic [63:0]      req_addr,
  input logic [7:0]       req_fmt,
  input logic [3:0]       req_be,
  input logic [31:0]      req_data,
  input logic             busy,
  input logic             done,
  input logic             bvalid,
  input logic             bready,
  input logic [1:0]       bresp,
  input logic             rvalid,
  input logic             rready,
  input logic [31:0]      rdata,
  input logic [1:0]       rresp,
  input logic [IRQ_W-1:0] irq_in,
  input logic [IRQ_W-1:0] irq_q
);
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_fmt)
                                 && $stable(req_be) && $stable(req_data));

  p_valid_busy_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    req_valid |-> busy);

  p_posted_done_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    req_valid && req_ready && req_fmt[6] && (req_fmt[4:0] == 5'd0) |=> !busy && done);

  p_b_hold_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    bvalid && !bready |=> bvalid && $stable(bresp));

  p_r_hold_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    rvalid && !rready |=> rvalid && $stable(rdata) && $stable(rresp));

  p_resp_legal_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    bvalid |-> (bresp == 2'b00 || bresp == 2'b10));

  p_irq_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n_s)
    (|irq_in) |=> ((irq_q & $past(irq_in)) == $past(irq_in)));
endmodule

bind dword_req_issuer dri_checker #(.IRQ_W(IRQ_W)) u_chk (
  .clk(clk), .rst_n_s(rst_n_s),
  .req_valid(req_valid_o), .req_ready(req_ready_i), .req_addr(req_addr_o),
  .req_fmt(req_fmt_o), .req_be(req_be_o), .req_data(req_data_o),
  .busy(busy), .done(done),
  .bvalid(s_bvalid_o), .bready(s_bready_i), .bresp(s_bresp_o),
  .rvalid(s_rvalid_o), .rready(s_rready_i), .rdata(s_rdata_o), .rresp(s_rresp_o),
  .irq_in(dma_irq_i), .irq_q(irq_q)
);

// File: tb/dword_req_issuer_test.sv
`timescale 1ns/1ps
module dword_req_issuer_test;
  localparam int ADDR_W = 12, NUM_DMA = 4, IRQ_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [ADDR_W-1:0] awaddr = '0, araddr = '0;
  logic awvalid = 1'b0, wvalid = 1'b0, arvalid = 1'b0;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic awready, wready, bvalid, arready, rvalid;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata_s;
  logic req_valid, req_ready = 1'b0;
  logic [63:0] req_addr;
  logic [7:0]  req_fmt;
  logic [3:0]  req_be;
  logic [31:0] req_data;
  logic cpl_valid = 1'b0;
  logic [31:0] cpl_data = '0;
  logic [NUM_DMA*32-1:0] dma_ctrl;
  logic [IRQ_W-1:0] dma_irq = '0;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  dword_req_issuer #(.ADDR_W(ADDR_W), .NUM_DMA(NUM_DMA), .IRQ_W(IRQ_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr_i(awaddr), .s_awvalid_i(awvalid), .s_awready_o(awready),
    .s_wdata_i(wdata), .s_wstrb_i(wstrb), .s_wvalid_i(wvalid), .s_wready_o(wready),
    .s_bresp_o(bresp), .s_bvalid_o(bvalid), .s_bready_i(1'b1),
    .s_araddr_i(araddr), .s_arvalid_i(arvalid), .s_arready_o(arready),
    .s_rdata_o(rdata_s), .s_rresp_o(rresp), .s_rvalid_o(rvalid), .s_rready_i(1'b1),
    .req_valid_o(req_valid), .req_ready_i(req_ready), .req_addr_o(req_addr),
    .req_fmt_o(req_fmt), .req_be_o(req_be), .req_data_o(req_data),
    .cpl_valid_i(cpl_valid), .cpl_data_i(cpl_data),
    .dma_ctrl_o(dma_ctrl), .dma_irq_i(dma_irq)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_aw(input logic [ADDR_W-1:0] a);
    awaddr = a; awvalid = 1'b1;
    while (!awready) @(negedge clk);
    @(negedge clk); awvalid = 1'b0;
  endtask

  task automatic send_w(input logic [31:0] d, input logic [3:0] s);
    wdata = d; wstrb = s; wvalid = 1'b1;
    while (!wready) @(negedge clk);
    @(negedge clk); wvalid = 1'b0;
  endtask

  task automatic axi_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                        input logic [3:0] s, input int order, output logic [1:0] r);
    if (order == 0) begin
      fork send_aw(a); send_w(d, s); join
    end else if (order == 1) begin
      send_aw(a); repeat (2) @(negedge clk); send_w(d, s);
    end else begin
      send_w(d, s); repeat (2) @(negedge clk); send_aw(a);
    end
    while (!bvalid) @(negedge clk);
    r = bresp;
    @(negedge clk);
  endtask

  task automatic axi_rd(input logic [ADDR_W-1:0] a, output logic [31:0] d, output logic [1:0] r);
    araddr = a; arvalid = 1'b1;
    while (!arready) @(negedge clk);
    @(negedge clk); arvalid = 1'b0;
    while (!rvalid) @(negedge clk);
    d = rdata_s; r = rresp;
    @(negedge clk);
  endtask

  task automatic pulse_cpl(input logic [31:0] d);
    cpl_data = d; cpl_valid = 1'b1;
    @(negedge clk); cpl_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [1:0]  r;
    logic [31:0] d, lo, wd, cd, exp_rd;
    logic [7:0]  fm;
    logic [3:0]  be;
    logic        posted, mapped;
    logic [ADDR_W-1:0] off;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 req_valid", 128'(req_valid), 128'(0));
    axi_rd(12'h14, d, r); chk("R1 status", 128'(d), 128'(0));
    axi_rd(12'h00, d, r); chk("R1 addr_lo", 128'(d), 128'(0));
    axi_rd(12'h18, d, r); chk("R1 rdata reg", 128'(d), 128'(0));
    chk("R1 dma_ctrl", 128'(dma_ctrl), 128'(0));

    // R2 strobe merge and control width
    axi_wr(12'h00, 32'hAABBCCDD, 4'hF, 0, r);
    axi_wr(12'h00, 32'h11223344, 4'b0101, 1, r);
    axi_rd(12'h00, d, r); chk("R2 strobe merge", 128'(d), 128'(32'hAA22CC44));
    axi_wr(12'h08, 32'hFFFFFFFF, 4'hF, 2, r);
    axi_rd(12'h08, d, r); chk("R2 ctrl width", 128'(d), 128'(32'h00000FFF));

    // R8 write orderings, one response each
    for (int o = 0; o < 3; o++) begin
      axi_wr(12'h0C, 32'h0BAD0000 + 32'(o), 4'hF, o, r);
      chk("R8 one B per write", 128'(bvalid), 128'(0));
      chk("R8 okay", 128'(r), 128'(2'b00));
      axi_rd(12'h0C, d, r); chk("R8 order data", 128'(d), 128'(32'h0BAD0000 + 32'(o)));
    end

    // R12 completion while idle ignored
    pulse_cpl(32'hDEADBEEF);
    axi_rd(12'h18, d, r); chk("R12 rdata unchanged", 128'(d), 128'(0));
    axi_rd(12'h14, d, r); chk("R12 no done", 128'(d), 128'(0));

    // R3/R4/R5 sweep over every format/type code
    axi_wr(12'h04, 32'h00000001, 4'hF, 0, r);
    exp_rd = 32'd0;
    for (int f = 0; f < 256; f++) begin
      fm = 8'(f);
      be = fm[3:0] ^ 4'h5;
      lo = 32'(f) * 32'h10 + 32'h1000;
      wd = {fm, ~fm, fm, 8'h3C};
      cd = {8'hC0, fm, ~fm, 8'h11};
      posted = fm[6] && (fm[4:0] == 5'd0);
      axi_wr(12'h08, {20'd0, be, fm}, 4'hF, f % 3, r);
      axi_wr(12'h00, lo, 4'hF, 0, r);
      axi_wr(12'h0C, wd, 4'hF, 0, r);
      axi_wr(12'h10, 32'd0, 4'hF, 0, r);
      chk("R3 valid", 128'(req_valid), 128'(1));
      chk("R3 fields", {20'd0, req_addr, req_fmt, req_be, req_data},
          {20'd0, 32'h1, lo, fm, be, wd});
      req_ready = 1'b1; @(negedge clk); req_ready = 1'b0;
      chk("R3 dropped after accept", 128'(req_valid), 128'(0));
      if (posted) begin
        axi_rd(12'h14, d, r); chk("R4 posted done", 128'(d), 128'(2));
      end else begin
        axi_rd(12'h14, d, r); chk("R5 busy until cpl", 128'(d), 128'(1));
        pulse_cpl(cd);
        if (!fm[6]) exp_rd = cd;
        axi_rd(12'h14, d, r); chk("R5 done after cpl", 128'(d), 128'(2));
        axi_rd(12'h18, d, r); chk("R5 read data reg", 128'(d), 128'(exp_rd));
      end
    end

    // R6 and R7: execute while busy, status clear on read
    axi_wr(12'h08, 32'h00000F00, 4'hF, 0, r);
    axi_wr(12'h00, 32'h00005000, 4'hF, 0, r);
    axi_wr(12'h10, 32'd0, 4'hF, 0, r);
    axi_wr(12'h00, 32'h00006000, 4'hF, 0, r);
    axi_wr(12'h10, 32'd0, 4'hF, 1, r);
    chk("R6 still valid", 128'(req_valid), 128'(1));
    chk("R6 fields kept", 128'(req_addr), 128'({32'h1, 32'h00005000}));
    axi_rd(12'h14, d, r); chk("R6 error set", 128'(d), 128'(5));
    axi_rd(12'h14, d, r); chk("R7 error cleared busy kept", 128'(d), 128'(1));
    req_ready = 1'b1; @(negedge clk); req_ready = 1'b0;
    chk("R6 single launch", 128'(req_valid), 128'(0));
    pulse_cpl(32'h12345678);
    axi_rd(12'h14, d, r); chk("R7 done read", 128'(d), 128'(2));
    axi_rd(12'h14, d, r); chk("R7 done cleared", 128'(d), 128'(0));
    axi_rd(12'h18, d, r); chk("R5 data after retry", 128'(d), 128'(32'h12345678));

    // R10 DMA control registers
    for (int k = 0; k < NUM_DMA; k++)
      axi_wr(12'(32'h100 + 4 * k), 32'hA0000000 | 32'(k * 7), 4'hF, k % 3, r);
    axi_wr(12'h104, 32'h00FF0000, 4'b0100, 0, r);
    for (int k = 0; k < NUM_DMA; k++) begin
      d = 32'hA0000000 | 32'(k * 7);
      if (k == 1) d = (d & 32'hFF00FFFF) | 32'h00FF0000;
      chk("R10 dma port", 128'(dma_ctrl[k*32 +: 32]), 128'(d));
      axi_rd(12'(32'h100 + 4 * k), lo, r);
      chk("R10 dma readback", 128'(lo), 128'(d));
    end

    // R11 sticky interrupts with write-one-to-clear
    dma_irq = 8'h05; @(negedge clk); dma_irq = 8'h00;
    axi_rd(12'h110, d, r); chk("R11 latched", 128'(d), 128'(8'h05));
    dma_irq = 8'h80; @(negedge clk); dma_irq = 8'h00;
    axi_rd(12'h110, d, r); chk("R11 accumulate", 128'(d), 128'(8'h85));
    axi_wr(12'h110, 32'h00000004, 4'hF, 0, r);
    axi_rd(12'h110, d, r); chk("R11 cleared bit", 128'(d), 128'(8'h81));

    // R9 response sweep over the map
    for (int a = 0; a < 'h140; a += 4) begin
      off = 12'(a);
      mapped = (a <= 'h18) || (a >= 'h100 && a <= 'h110);
      axi_rd(off, d, r);
      chk("R9 read resp", 128'(r), 128'(mapped ? 2'b00 : 2'b10));
    end
    axi_wr(12'h114, 32'hFFFFFFFF, 4'hF, 0, r);
    chk("R9 unmapped write resp", 128'(r), 128'(2'b10));
    axi_wr(12'h020, 32'hFFFFFFFF, 4'hF, 2, r);
    chk("R9 unmapped write resp low", 128'(r), 128'(2'b10));
    axi_rd(12'h110, d, r); chk("R9 irq untouched", 128'(d), 128'(8'h81));
    chk("R9 dma untouched", 128'(dma_ctrl[0 +: 32]), 128'(32'hA0000000));
    axi_rd(12'h00, d, r); chk("R9 addr_lo untouched", 128'(d), 128'(32'h00006000));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule